// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core that executes a fixed set of 32-bit integer instructions. The set covers register-register arithmetic and logic, the immediate forms of the same operations, word loads and stores, and two conditional branches. Each instruction moves through five stages: fetch, decode, execute, memory access and register writeback. Pipeline registers separate the stages, and both control and data travel through them.

The program image is a parameter, so the instruction memory is fixed when the design elaborates. The core never writes it. Data memory is word-indexed: the sum of the base register and the offset selects a word directly. Each store also appears on a set of observation outputs, so a surrounding bench can follow every result the program commits to memory without looking inside the core.

Top module: `pipe_core`

## Requirements
- R1: R-type instructions (opcode 000000) pick their operation from the low six bits. The codes are add 100000, sub 100010, and 100100, or 100101 and slt 101010. The result is written to the register in bits 15:11.
- R2: Immediate instructions write to the register in bits 20:16. The opcodes are addi 001000, andi 001100, ori 001101 and slti 001010. addi and slti sign-extend the 16-bit immediate, while andi and ori zero-extend it.
- R3: slt and slti compare as signed two's-complement numbers and write exactly 1 or 0.
- R4: Register 0 always reads as zero. Any write to it is dropped.
- R5: A result from either of the two previous instructions reaches a dependent instruction's operands without a stall. The newer producer wins when both match.
- R6: A load (opcode 100011) followed directly by an instruction that uses its destination inserts exactly one bubble. A store uses opcode 100011's partner, 101011. Both address the data memory with the word index base + sign-extended offset.
- R7: beq (000100) and bne (000101) are resolved in execute. A taken branch jumps to PC+4 + (sign-extended offset << 2) and discards the two younger instructions, so a loop of four instructions ending in a taken branch repeats every 6 cycles.
- R8: Each executed store raises `st_valid` for exactly one cycle, with its word address and data. Stores appear in program order.
- R9: Reset sets the fetch address to 0 and empties the pipeline. No store is flagged during reset or in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | output | 1 | A store is being committed this cycle |
| st_addr | output | 5 | Word index of the committed store |
| st_data | output | 32 | Data of the committed store |

## Verification
Embedded properties check several things on every cycle: that a load-use stall holds the fetch address and never lasts more than one cycle, that a taken branch leaves both younger slots empty, that register 0 reads as zero, and that no store is flagged right after reset. The arithmetic, the immediate extension rules, the signed comparisons, forwarding and the branch target all show up only through the stored values. The bench runs an accumulate loop followed by a series of corner-case stores and compares each one with its expected address and data. The spacing between selected stores confirms the branch penalty and the single load-use bubble.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_ADDI  = 6'b001000;
   localparam logic [5:0] OPC_SLTI  = 6'b001010;
   localparam logic [5:0] OPC_ANDI  = 6'b001100;
   localparam logic [5:0] OPC_ORI   = 6'b001101;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_BNE   = 6'b000101;
   localparam logic [5:0] OPC_LW    = 6'b100011;
   localparam logic [5:0] OPC_SW    = 6'b101011;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    mem_rd;
      logic    mem_wr;
      logic    use_imm;
      logic    zero_ext;
      logic    br_eq;
      logic    br_ne;
      alu_op_e alu_op;
   } ctrl_t;

   typedef enum logic [1:0] {
      FWD_NONE, FWD_MEM, FWD_WB
   } fwd_e;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
   import pipe_pkg::*;
(
   input  logic [31:0] instr,
   output ctrl_t       ctrl,
   output logic [4:0]  dst
);
   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];
   assign dst = (opc == OPC_RTYPE) ? instr[15:11] : instr[20:16];

   always_comb begin
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opc)
         OPC_RTYPE: begin
            ctrl.reg_we = 1'b1;
            unique case (fn)
               FN_ADD:  ctrl.alu_op = ALU_ADD;
               FN_SUB:  ctrl.alu_op = ALU_SUB;
               FN_AND:  ctrl.alu_op = ALU_AND;
               FN_OR:   ctrl.alu_op = ALU_OR;
               FN_SLT:  ctrl.alu_op = ALU_SLT;
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OPC_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_SLTI: begin
            ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT;
         end
         OPC_ANDI: begin
            ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zero_ext = 1'b1;
            ctrl.alu_op = ALU_AND;
         end
         OPC_ORI: begin
            ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zero_ext = 1'b1;
            ctrl.alu_op = ALU_OR;
         end
         OPC_LW: begin ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_SW: begin ctrl.mem_wr = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_BEQ: ctrl.br_eq = 1'b1;
         OPC_BNE: ctrl.br_ne = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
   import pipe_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);
   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [RAW-1:0]  ra1,
   input  logic [RAW-1:0]  ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   input  logic            we,
   input  logic [RAW-1:0]  wa,
   input  logic [XLEN-1:0] wd
);
   logic [XLEN-1:0] regs [NREG];

   if (NREG < 2 || (1 << RAW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end

   assign regs[0] = '0;
   for (genvar g = 1; g < NREG; g++) begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)                         q <= '0;
         else if (we && wa == RAW'(g))    q <= wd;
      end
      assign regs[g] = q;
   end

   // write-through so that decode sees the value retiring this cycle
   assign rd1 = (we && ra1 != '0 && wa == ra1) ? wd : regs[ra1];
   assign rd2 = (we && ra2 != '0 && wa == ra2) ? wd : regs[ra2];

   a_r4_zero_reads: assert property (@(posedge clk) disable iff (rst)
      (ra1 == '0) |-> (rd1 == '0));
endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
   import pipe_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       id_valid,
   input  logic [4:0] id_rs,
   input  logic [4:0] id_rt,
   input  logic       ex_valid,
   input  logic       ex_load,
   input  logic [4:0] ex_dst,
   input  logic [4:0] ex_rs,
   input  logic [4:0] ex_rt,
   input  logic       mem_we,
   input  logic       mem_load,
   input  logic [4:0] mem_dst,
   input  logic       wb_we,
   input  logic [4:0] wb_dst,
   output logic       stall,
   output fwd_e       fwd_a,
   output fwd_e       fwd_b
);
   function automatic fwd_e pick(input logic [4:0] src);
      if (mem_we && !mem_load && mem_dst != '0 && mem_dst == src) return FWD_MEM;
      if (wb_we && wb_dst != '0 && wb_dst == src)                  return FWD_WB;
      return FWD_NONE;
   endfunction

   assign fwd_a = pick(ex_rs);
   assign fwd_b = pick(ex_rt);
   assign stall = id_valid && ex_valid && ex_load && ex_dst != '0 &&
                  (ex_dst == id_rs || ex_dst == id_rt);

   a_r6_one_bubble: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall);
endmodule

// File: rtl/pipe_core.sv
module pipe_core
   import pipe_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int IMEM_DEPTH = 32,
   parameter int DMEM_DEPTH = 32,
   parameter logic [IMEM_DEPTH*32-1:0] PROG = '0,
   localparam int IAW = $clog2(IMEM_DEPTH),
   localparam int DAW = $clog2(DMEM_DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   output logic            st_valid,
   output logic [DAW-1:0]  st_addr,
   output logic [XLEN-1:0] st_data
);
   if (XLEN != 32)                                     begin : g_bad_xlen $error("XLEN must be 32"); end
   if (NREG != 32)                                     begin : g_bad_nreg $error("five-bit register fields need NREG 32"); end
   if (IMEM_DEPTH < 2 || (1 << IAW) != IMEM_DEPTH)     begin : g_bad_imem $error("IMEM_DEPTH must be a power of two"); end
   if (DMEM_DEPTH < 2 || (1 << DAW) != DMEM_DEPTH)     begin : g_bad_dmem $error("DMEM_DEPTH must be a power of two"); end

   // ---------------- fetch ----------------
   logic [XLEN-1:0] pc, pc4;
   logic [31:0]     f_instr;
   logic [IAW-1:0]  f_idx;
   assign f_idx   = pc[IAW+1:2];
   assign f_instr = PROG[f_idx*32 +: 32];
   assign pc4     = pc + XLEN'(4);

   logic            ifid_valid;
   logic [31:0]     ifid_instr;
   logic [XLEN-1:0] ifid_pc4;

   // ---------------- decode ----------------
   ctrl_t           d_ctrl;
   logic [4:0]      d_dst, d_rs, d_rt;
   logic [XLEN-1:0] d_rd1, d_rd2, d_imm;
   assign d_rs  = ifid_instr[25:21];
   assign d_rt  = ifid_instr[20:16];
   assign d_imm = d_ctrl.zero_ext ? {16'b0, ifid_instr[15:0]}
                                  : {{16{ifid_instr[15]}}, ifid_instr[15:0]};

   pipe_decode u_dec (.instr(ifid_instr), .ctrl(d_ctrl), .dst(d_dst));

   logic            idex_valid;
   ctrl_t           idex_ctrl;
   logic [4:0]      idex_rs, idex_rt, idex_dst;
   logic [XLEN-1:0] idex_rd1, idex_rd2, idex_imm, idex_pc4;

   // ---------------- execute ----------------
   logic            exmem_valid, exmem_we, exmem_rd, exmem_wr;
   logic [4:0]      exmem_dst;
   logic [XLEN-1:0] exmem_y, exmem_sd;
   logic            memwb_valid, memwb_we;
   logic [4:0]      memwb_dst;
   logic [XLEN-1:0] memwb_wd;

   logic            stall, take;
   fwd_e            fwd_a, fwd_b;
   logic [XLEN-1:0] x_a, x_b, x_y, x_target;

   pipe_hazard u_haz (
      .clk(clk), .rst(rst),
      .id_valid(ifid_valid), .id_rs(d_rs), .id_rt(d_rt),
      .ex_valid(idex_valid), .ex_load(idex_ctrl.mem_rd), .ex_dst(idex_dst),
      .ex_rs(idex_rs), .ex_rt(idex_rt),
      .mem_we(exmem_valid && exmem_we), .mem_load(exmem_rd), .mem_dst(exmem_dst),
      .wb_we(memwb_valid && memwb_we), .wb_dst(memwb_dst),
      .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b));

   always_comb begin
      unique case (fwd_a)
         FWD_MEM: x_a = exmem_y;
         FWD_WB:  x_a = memwb_wd;
         default: x_a = idex_rd1;
      endcase
      unique case (fwd_b)
         FWD_MEM: x_b = exmem_y;
         FWD_WB:  x_b = memwb_wd;
         default: x_b = idex_rd2;
      endcase
   end

   pipe_alu #(.XLEN(XLEN)) u_alu (
      .a(x_a), .b(idex_ctrl.use_imm ? idex_imm : x_b), .op(idex_ctrl.alu_op), .y(x_y));

   assign take = idex_valid && ((idex_ctrl.br_eq && x_a == x_b) ||
                                (idex_ctrl.br_ne && x_a != x_b));
   assign x_target = idex_pc4 + {idex_imm[XLEN-3:0], 2'b00};

   // ---------------- memory ----------------
   logic [XLEN-1:0] dmem [DMEM_DEPTH];
   logic [XLEN-1:0] m_rdata;
   assign m_rdata = dmem[exmem_y[DAW-1:0]];

   always_ff @(posedge clk) begin
      if (exmem_valid && exmem_wr) dmem[exmem_y[DAW-1:0]] <= exmem_sd;
   end

   // ---------------- writeback ----------------
   pipe_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst(rst), .ra1(d_rs), .ra2(d_rt), .rd1(d_rd1), .rd2(d_rd2),
      .we(memwb_valid && memwb_we && memwb_dst != '0), .wa(memwb_dst), .wd(memwb_wd));

   // ---------------- pipeline registers ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         pc          <= '0;
         ifid_valid  <= 1'b0;
         ifid_instr  <= '0;
         ifid_pc4    <= '0;
         idex_valid  <= 1'b0;
         idex_ctrl   <= '0;
         idex_rs     <= '0;
         idex_rt     <= '0;
         idex_dst    <= '0;
         idex_rd1    <= '0;
         idex_rd2    <= '0;
         idex_imm    <= '0;
         idex_pc4    <= '0;
         exmem_valid <= 1'b0;
         exmem_we    <= 1'b0;
         exmem_rd    <= 1'b0;
         exmem_wr    <= 1'b0;
         exmem_dst   <= '0;
         exmem_y     <= '0;
         exmem_sd    <= '0;
         memwb_valid <= 1'b0;
         memwb_we    <= 1'b0;
         memwb_dst   <= '0;
         memwb_wd    <= '0;
      end else begin
         // front end: flush beats stall (they never coincide)
         if (take) begin
            pc         <= x_target;
            ifid_valid <= 1'b0;
            idex_valid <= 1'b0;
         end else if (stall) begin
            idex_valid <= 1'b0;
         end else begin
            pc         <= pc4;
            ifid_valid <= 1'b1;
            ifid_instr <= f_instr;
            ifid_pc4   <= pc4;
            idex_valid <= ifid_valid;
         end
         idex_ctrl <= d_ctrl;
         idex_rs   <= d_rs;
         idex_rt   <= d_rt;
         idex_dst  <= d_dst;
         idex_rd1  <= d_rd1;
         idex_rd2  <= d_rd2;
         idex_imm  <= d_imm;
         idex_pc4  <= ifid_pc4;

         exmem_valid <= idex_valid;
         exmem_we    <= idex_ctrl.reg_we;
         exmem_rd    <= idex_ctrl.mem_rd;
         exmem_wr    <= idex_ctrl.mem_wr;
         exmem_dst   <= idex_dst;
         exmem_y     <= x_y;
         exmem_sd    <= x_b;

         memwb_valid <= exmem_valid;
         memwb_we    <= exmem_we;
         memwb_dst   <= exmem_dst;
         memwb_wd    <= exmem_rd ? m_rdata : exmem_y;
      end
   end

   assign st_valid = exmem_valid && exmem_wr;
   assign st_addr  = exmem_y[DAW-1:0];
   assign st_data  = exmem_sd;

   a_r6_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc));
   a_r7_flush_two: assert property (@(posedge clk) disable iff (rst)
      take |=> (!ifid_valid && !idex_valid));
   a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !st_valid);
endmodule

// File: tb/tb_pipe_core.sv
module tb_pipe_core;
   localparam int NW = 32;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic logic [NW*32-1:0] build_prog();
      logic [NW*32-1:0] p;
      p = '0;
      p[ 0*32 +: 32] = enc_i(6'b001000, 0, 1, 1);        // addi r1,r0,1
      p[ 1*32 +: 32] = enc_i(6'b001000, 0, 2, 0);        // addi r2,r0,0
      p[ 2*32 +: 32] = enc_i(6'b001000, 0, 3, 11);       // addi r3,r0,11
      p[ 3*32 +: 32] = enc_r(2, 1, 2, 6'b100000);        // add r2,r2,r1
      p[ 4*32 +: 32] = enc_i(6'b101011, 1, 2, 0);        // sw r2,0(r1)
      p[ 5*32 +: 32] = enc_i(6'b001000, 1, 1, 1);        // addi r1,r1,1
      p[ 6*32 +: 32] = enc_i(6'b000101, 1, 3, -4);       // bne r1,r3,loop
      p[ 7*32 +: 32] = enc_i(6'b100011, 0, 4, 5);        // lw r4,5(r0)
      p[ 8*32 +: 32] = enc_r(4, 4, 5, 6'b100000);        // add r5,r4,r4
      p[ 9*32 +: 32] = enc_i(6'b101011, 0, 5, 0);        // sw r5,0(r0)
      p[10*32 +: 32] = enc_r(0, 1, 6, 6'b100010);        // sub r6,r0,r1
      p[11*32 +: 32] = enc_r(6, 0, 7, 6'b101010);        // slt r7,r6,r0
      p[12*32 +: 32] = enc_i(6'b101011, 0, 7, 20);       // sw r7,20
      p[13*32 +: 32] = enc_i(6'b001101, 0, 8, 'h8000);   // ori r8,r0,0x8000
      p[14*32 +: 32] = enc_i(6'b101011, 0, 8, 21);       // sw r8,21
      p[15*32 +: 32] = enc_i(6'b001000, 0, 9, -1);       // addi r9,r0,-1
      p[16*32 +: 32] = enc_i(6'b001100, 9, 10, 'hF0F0);  // andi r10,r9,0xF0F0
      p[17*32 +: 32] = enc_i(6'b101011, 0, 10, 22);      // sw r10,22
      p[18*32 +: 32] = enc_i(6'b001010, 6, 11, -5);      // slti r11,r6,-5
      p[19*32 +: 32] = enc_i(6'b101011, 0, 11, 23);      // sw r11,23
      p[20*32 +: 32] = enc_i(6'b001000, 0, 0, 5);        // addi r0,r0,5
      p[21*32 +: 32] = enc_i(6'b101011, 0, 0, 24);       // sw r0,24
      p[22*32 +: 32] = enc_r(9, 3, 12, 6'b100100);       // and r12,r9,r3
      p[23*32 +: 32] = enc_r(12, 8, 13, 6'b100101);      // or r13,r12,r8
      p[24*32 +: 32] = enc_i(6'b101011, 0, 12, 25);      // sw r12,25
      p[25*32 +: 32] = enc_i(6'b101011, 0, 13, 26);      // sw r13,26
      p[26*32 +: 32] = enc_r(0, 6, 14, 6'b101010);       // slt r14,r0,r6
      p[27*32 +: 32] = enc_i(6'b101011, 0, 14, 27);      // sw r14,27
      p[28*32 +: 32] = enc_i(6'b000100, 0, 0, 1);        // beq r0,r0,+1
      p[29*32 +: 32] = enc_i(6'b101011, 0, 9, 30);       // sw r9,30 (skipped)
      p[30*32 +: 32] = enc_i(6'b101011, 0, 9, 31);       // sw r9,31
      p[31*32 +: 32] = enc_i(6'b000100, 0, 0, -1);       // beq r0,r0,self
      return p;
   endfunction

   localparam logic [NW*32-1:0] PROG_IMG = build_prog();

   // expected stores {addr, data} in program order
   localparam int NV = 20;
   localparam logic [36:0] EXP [NV] = '{
      {5'd1, 32'd1},  {5'd2, 32'd3},  {5'd3, 32'd6},  {5'd4, 32'd10},
      {5'd5, 32'd15}, {5'd6, 32'd21}, {5'd7, 32'd28}, {5'd8, 32'd36},
      {5'd9, 32'd45}, {5'd10, 32'd55},
      {5'd0, 32'd30},                  // R6 load then dependent add
      {5'd20, 32'd1},                  // R3 slt -11<0
      {5'd21, 32'h0000_8000},          // R2 ori zero-extends
      {5'd22, 32'h0000_F0F0},          // R2 andi zero-extends
      {5'd23, 32'd1},                  // R3 slti signed
      {5'd24, 32'd0},                  // R4 write to r0 dropped
      {5'd25, 32'd11},                 // R1 and
      {5'd26, 32'h0000_800B},          // R1 or, R5 forwarding
      {5'd27, 32'd0},                  // R3 0 < -11 is false
      {5'd31, 32'hFFFF_FFFF}           // R7 skipped store absent
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        st_valid;
   logic [4:0]  st_addr;
   logic [31:0] st_data;

   always #5 clk = ~clk;

   pipe_core #(.IMEM_DEPTH(NW), .DMEM_DEPTH(32), .PROG(PROG_IMG)) dut (
      .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data));

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   int stamp [NV];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // wait at falling edges for the next store; returns 0 on timeout
   task automatic next_store(output bit got);
      got = 1'b0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (st_valid) begin got = 1'b1; return; end
      end
   endtask

   initial begin : watchdog
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit got;
      // R9: quiet during reset
      repeat (3) @(negedge clk);
      check(st_valid == 1'b0, "R9 reset", 64'(st_valid), 64'd0);
      rst = 1'b0;

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         next_store(got);
         stamp[v] = cyc;
         check(got && {st_addr, st_data} == EXP[v], "R8 store",
               got ? 64'({st_addr, st_data}) : 64'hDEAD, 64'(EXP[v]));
      end

      // R7: taken-branch loop of four instructions repeats every 6 cycles
      check(stamp[1] - stamp[0] == 6, "R7 loop period", 64'(stamp[1] - stamp[0]), 64'd6);
      check(stamp[9] - stamp[8] == 6, "R7 loop period", 64'(stamp[9] - stamp[8]), 64'd6);
      // R6: addi, bne, lw, bubble, add, sw -> 6 cycles after last loop store
      check(stamp[10] - stamp[9] == 6, "R6 load-use bubble", 64'(stamp[10] - stamp[9]), 64'd6);
      // R5: back-to-back dependents stored on consecutive cycles
      check(stamp[17] - stamp[16] == 1, "R5 no stall", 64'(stamp[17] - stamp[16]), 64'd1);

      // R7: spinning branch stores nothing further
      begin
         int extra = 0;
         for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (st_valid) extra++;
         end
         check(extra == 0, "R7 idle spin", 64'(extra), 64'd0);
      end

      // R9: reset mid-run restarts from address 0
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(st_valid == 1'b0, "R9 reset hold", 64'(st_valid), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check(st_valid == 1'b0, "R9 after release", 64'(st_valid), 64'd0);
      next_store(got);
      check(got && {st_addr, st_data} == EXP[0], "R9 restart",
            got ? 64'({st_addr, st_data}) : 64'hDEAD, 64'(EXP[0]));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule